// File: doc/BRIEF.md
# Synthesizer Serial Programming Port

This block is the control port of a frequency synthesizer. Three lines drive it: a serial clock, a serial data line and a strobe. While the strobe is low, data bits enter a shift register, most significant bit first. When the strobe rises, the block decodes the word it has collected. Depending on the word's header, it loads divider ratios, charge-pump scaling factors and enable bits into working registers, or it parks some of them in staging registers.

Main-divider words need special care. A main-divider word is never applied as soon as it arrives. Instead it becomes a pending load, which also captures the staged current factor and prescaler mode. The block applies all of it in a single cycle, and only when the main divider reports through `load_ok_i` that a reload cannot disturb its phase. Once a main-divider word has been applied, a speed-up indication stays asserted until the strobe falls again.

The serial lines are sampled by the system clock, so the serial clock must run well below it. The outputs feed the dividers, the reference selector and the pump current digital-to-analog converters.

Top module: `synth_prog_port`

## Requirements
- R1: A bit is shifted in on each rising edge of `ser_clk_i` seen while `ser_stb_i` is low. Rising edges seen while the strobe is high are neither shifted nor counted toward the word length.
- R2: On each strobe rise, the bits collected since the previous rise are decoded, first bit as the most significant. A 24-bit word with a leading 1 is a control word, and its top four bits select it:
  - 1000 selects the staging word.
  - 1001 selects the auxiliary word.
  - 1010 selects the setup word.
  - 1111 selects the test word.

  Any other header, and any bit count other than 24 or 32, leaves every register unchanged.
- R3: The auxiliary word places the auxiliary ratio in bits 19:8 and the divide-by-4 bypass in bit 0. The setup word places the following fields:
  - reference ratio in bits 19:8;
  - main reference select in bits 7:6;
  - auxiliary reference select in bits 5:4;
  - main enable in bit 3;
  - auxiliary enable in bit 2;
  - modulo-8 flag in bit 1;
  - long-format flag in bit 0.

  The test word places the test select in bits 1:0.
- R4: Writing the setup word clears the test select to 0.
- R5: The staging word places the current factor in bits 19:12, the integral acceleration in bits 11:8, the proportional acceleration in bits 7:6 and the prescaler mode in bits 5:4. The two acceleration fields take effect at once. The current factor and the prescaler mode reach the outputs only when a later main-divider word is applied.
- R6: When the long flag is 0, a main-divider word is 24 bits with a leading 0. Its fields are: fraction increment in bits 22:20, first count in bits 19:8 and low count byte in bits 7:0. The current factor for this word is taken from staging. When the long flag is 1, a main-divider word is 32 bits with a leading 0. Its fields are: fraction increment in bits 30:28, first count in bits 27:16, low count byte in bits 15:8 and current factor in bits 7:0. A main-divider word of the length the flag does not select is ignored.
- R7: When the applied prescaler mode is 2'b10, the second count is the upper nibble of the low byte and the third count is the lower nibble. Otherwise the second count is the whole byte and the third count is 0.
- R8: A decoded main-divider word is applied only in a cycle in which `load_ok_i` is high. Until then it stays pending, and a newer main-divider word replaces the pending one.
- R9: `speed_up_o` rises when a main-divider word is applied while the strobe is high. It stays high while the strobe stays high and is 0 in the cycle after the strobe is seen low.
- R10: After reset every output is 0, so both divider enables start off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| ser_clk_i | input | 1 | serial shift clock |
| ser_data_i | input | 1 | serial data |
| ser_stb_i | input | 1 | strobe; low = shift, rise = decode |
| load_ok_i | input | 1 | main divider safe-reload window |
| frac_inc_o | output | 3 | fraction increment |
| cnt_a_o | output | 12 | first main count |
| cnt_b_o | output | 8 | second main count |
| cnt_c_o | output | 4 | third main count |
| pre_mode_o | output | 2 | prescaler mode |
| cur_fac_o | output | 8 | pump current factor |
| int_acc_o | output | 4 | integral acceleration |
| prop_acc_o | output | 2 | proportional acceleration |
| aux_ratio_o | output | 12 | auxiliary ratio |
| aux_byp_o | output | 1 | auxiliary divide-by-4 bypass |
| ref_ratio_o | output | 12 | reference ratio |
| main_rsel_o | output | 2 | main reference select |
| aux_rsel_o | output | 2 | auxiliary reference select |
| main_en_o | output | 1 | main divider enable |
| aux_en_o | output | 1 | auxiliary divider enable |
| mod8_o | output | 1 | fraction modulo 8 (else 5) |
| long_fmt_o | output | 1 | 32-bit main-word format |
| test_sel_o | output | 2 | test output select |
| speed_up_o | output | 1 | speed-up indication |

## Verification
The block has no parameters, so the bench builds it in its one fixed shape. Covering it therefore means exercising both main-word formats and both prescaler modes through the long-flag and staging words.

Random word sequences mix every header, and the setup word often flips the long flag, so the length rule is hit in both directions. Directed cases cover the following:
- a closed window holding a pending load;
- a newer main-divider word replacing the pending one;
- junk clock edges while the strobe is high;
- bad lengths and an unused header;
- the speed-up flag rising late when the window opens after the strobe.

// File: rtl/synth_prog_port.sv
module synth_prog_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk_i,
  input  logic        ser_data_i,
  input  logic        ser_stb_i,
  input  logic        load_ok_i,
  output logic [2:0]  frac_inc_o,
  output logic [11:0] cnt_a_o,
  output logic [7:0]  cnt_b_o,
  output logic [3:0]  cnt_c_o,
  output logic [1:0]  pre_mode_o,
  output logic [7:0]  cur_fac_o,
  output logic [3:0]  int_acc_o,
  output logic [1:0]  prop_acc_o,
  output logic [11:0] aux_ratio_o,
  output logic        aux_byp_o,
  output logic [11:0] ref_ratio_o,
  output logic [1:0]  main_rsel_o,
  output logic [1:0]  aux_rsel_o,
  output logic        main_en_o,
  output logic        aux_en_o,
  output logic        mod8_o,
  output logic        long_fmt_o,
  output logic [1:0]  test_sel_o,
  output logic        speed_up_o
);

  logic        sclk_q, sclk_qq, stb_q, stb_qq, data_q;
  logic [31:0] shreg;
  logic [5:0]  nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; sclk_qq <= 1'b0;
      stb_q  <= 1'b0; stb_qq  <= 1'b0;
      data_q <= 1'b0;
    end else begin
      sclk_q <= ser_clk_i;  sclk_qq <= sclk_q;
      stb_q  <= ser_stb_i;  stb_qq  <= stb_q;
      data_q <= ser_data_i;
    end
  end

  wire shift_en = sclk_q & ~sclk_qq & ~stb_q;
  wire stb_rise = stb_q & ~stb_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      nbits <= '0;
    end else begin
      if (shift_en) shreg <= {shreg[30:0], data_q};
      if (stb_rise) nbits <= '0;
      else if (shift_en && nbits != 6'd63) nbits <= nbits + 6'd1;
    end
  end

  // decode
  logic        long_r;
  wire  [3:0]  hdr    = shreg[23:20];
  wire         len24  = (nbits == 6'd24);
  wire         len32  = (nbits == 6'd32);
  wire         ctl    = stb_rise & len24 & shreg[23];
  wire         a_shrt = stb_rise & len24 & ~shreg[23] & ~long_r;
  wire         a_lng  = stb_rise & len32 & ~shreg[31] & long_r;
  wire         a_hit  = a_shrt | a_lng;
  wire         b_hit  = ctl & (hdr == 4'b1000);
  wire         c_hit  = ctl & (hdr == 4'b1001);
  wire         d_hit  = ctl & (hdr == 4'b1010);
  wire         e_hit  = ctl & (hdr == 4'b1111);

  // staging and pending load
  logic [7:0]  stg_cf;
  logic [1:0]  stg_pm;
  logic        pend;
  logic [2:0]  p_fi;
  logic [11:0] p_ca;
  logic [7:0]  p_lo, p_cf;
  logic [1:0]  p_pm;

  wire commit = pend & load_ok_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_cf <= '0; stg_pm <= '0;
      int_acc_o <= '0; prop_acc_o <= '0;
    end else if (b_hit) begin
      stg_cf     <= shreg[19:12];
      int_acc_o  <= shreg[11:8];
      prop_acc_o <= shreg[7:6];
      stg_pm     <= shreg[5:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      p_fi <= '0; p_ca <= '0; p_lo <= '0; p_cf <= '0; p_pm <= '0;
    end else begin
      if (a_hit) begin
        pend <= 1'b1;
        p_fi <= a_lng ? shreg[30:28] : shreg[22:20];
        p_ca <= a_lng ? shreg[27:16] : shreg[19:8];
        p_lo <= a_lng ? shreg[15:8]  : shreg[7:0];
        p_cf <= a_lng ? shreg[7:0]   : stg_cf;
        p_pm <= stg_pm;
      end else if (commit) begin
        pend <= 1'b0;
      end
    end
  end

  // working main registers
  logic [7:0] lo_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_inc_o <= '0; cnt_a_o <= '0; lo_r <= '0;
      cur_fac_o <= '0; pre_mode_o <= '0;
    end else if (commit) begin
      frac_inc_o <= p_fi;
      cnt_a_o    <= p_ca;
      lo_r       <= p_lo;
      cur_fac_o  <= p_cf;
      pre_mode_o <= p_pm;
    end
  end

  wire tri_mod = (pre_mode_o == 2'b10);
  assign cnt_b_o = tri_mod ? {4'd0, lo_r[7:4]} : lo_r;
  assign cnt_c_o = tri_mod ? lo_r[3:0] : 4'd0;

  // auxiliary, setup, test words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_ratio_o <= '0; aux_byp_o <= 1'b0;
    end else if (c_hit) begin
      aux_ratio_o <= shreg[19:8];
      aux_byp_o   <= shreg[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_ratio_o <= '0; main_rsel_o <= '0; aux_rsel_o <= '0;
      main_en_o <= 1'b0; aux_en_o <= 1'b0; mod8_o <= 1'b0; long_r <= 1'b0;
    end else if (d_hit) begin
      ref_ratio_o <= shreg[19:8];
      main_rsel_o <= shreg[7:6];
      aux_rsel_o  <= shreg[5:4];
      main_en_o   <= shreg[3];
      aux_en_o    <= shreg[2];
      mod8_o      <= shreg[1];
      long_r      <= shreg[0];
    end
  end
  assign long_fmt_o = long_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      test_sel_o <= '0;
    else if (d_hit)  test_sel_o <= '0;
    else if (e_hit)  test_sel_o <= shreg[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) speed_up_o <= 1'b0;
    else        speed_up_o <= stb_q & (speed_up_o | commit);
  end

  // assertions
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> $stable(shreg));

  p_eclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    d_hit |=> (test_sel_o == 2'b00));

  p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cnt_a_o) || !$stable(cur_fac_o) || !$stable(pre_mode_o)) |-> $past(pend && load_ok_i));

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && load_ok_i && !a_hit) |=> !pend);

  p_speed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |=> !speed_up_o);

  p_speed_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(speed_up_o) |-> $past(commit));

endmodule

// File: tb/synth_prog_port_tb.sv
module synth_prog_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sstb = 1'b1, lok = 1'b1;
  logic [2:0] fi; logic [11:0] ca; logic [7:0] cb; logic [3:0] cc;
  logic [1:0] pm; logic [7:0] cf; logic [3:0] ia; logic [1:0] pa;
  logic [11:0] ar; logic ab; logic [11:0] rr; logic [1:0] ms, as_;
  logic me, ae, m8, lf; logic [1:0] ts; logic su;

  always #4 clk = ~clk;

  synth_prog_port dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_data_i(sdata),
    .ser_stb_i(sstb), .load_ok_i(lok),
    .frac_inc_o(fi), .cnt_a_o(ca), .cnt_b_o(cb), .cnt_c_o(cc),
    .pre_mode_o(pm), .cur_fac_o(cf), .int_acc_o(ia), .prop_acc_o(pa),
    .aux_ratio_o(ar), .aux_byp_o(ab), .ref_ratio_o(rr), .main_rsel_o(ms),
    .aux_rsel_o(as_), .main_en_o(me), .aux_en_o(ae), .mod8_o(m8),
    .long_fmt_o(lf), .test_sel_o(ts), .speed_up_o(su));

  int total = 0, bad = 0;
  bit done = 0;

  // bench model
  logic [2:0] e_fi; logic [11:0] e_ca; logic [7:0] e_lo, e_cf; logic [1:0] e_pm;
  logic [7:0] s_cf; logic [1:0] s_pm; logic [3:0] e_ia; logic [1:0] e_pa;
  logic [11:0] e_ar; logic e_ab; logic [11:0] e_rr; logic [1:0] e_ms, e_as;
  logic e_me, e_ae, e_m8, e_lf; logic [1:0] e_ts;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_b(input logic [1:0] m, input logic [7:0] lo);
    return (m == 2'b10) ? {4'd0, lo[7:4]} : lo;
  endfunction
  function automatic logic [3:0] exp_c(input logic [1:0] m, input logic [7:0] lo);
    return (m == 2'b10) ? lo[3:0] : 4'd0;
  endfunction

  task automatic check_all(input string req);
    chk(req, "frac", fi, e_fi);   chk(req, "cnt_a", ca, e_ca);
    chk(req, "cnt_b", cb, exp_b(e_pm, e_lo)); chk(req, "cnt_c", cc, exp_c(e_pm, e_lo));
    chk(req, "pmode", pm, e_pm);  chk(req, "curfac", cf, e_cf);
    chk(req, "intacc", ia, e_ia); chk(req, "propacc", pa, e_pa);
    chk(req, "auxr", ar, e_ar);   chk(req, "auxbyp", ab, e_ab);
    chk(req, "refr", rr, e_rr);   chk(req, "msel", ms, e_ms);
    chk(req, "asel", as_, e_as);  chk(req, "men", me, e_me);
    chk(req, "aen", ae, e_ae);    chk(req, "mod8", m8, e_m8);
    chk(req, "long", lf, e_lf);   chk(req, "tsel", ts, e_ts);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // junk = clock edges given while strobe is still high (must be ignored)
  task automatic send(input logic [31:0] w, input int n, input int junk);
    for (int j = 0; j < junk; j++) begin
      sdata = j[0]; sclk = 1'b1; cyc(2); sclk = 1'b0; cyc(2);
    end
    sstb = 1'b0; cyc(2);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i]; cyc(2); sclk = 1'b1; cyc(2); sclk = 1'b0;
    end
    cyc(2); sstb = 1'b1; cyc(6);
  endtask

  function automatic logic [31:0] w_b(input logic [7:0] c, input logic [3:0] k, input logic [1:0] l, input logic [1:0] p);
    return {8'd0, 4'b1000, c, k, l, p, 4'd0};
  endfunction
  function automatic logic [31:0] w_c(input logic [11:0] r, input logic b);
    return {8'd0, 4'b1001, r, 7'd0, b};
  endfunction
  function automatic logic [31:0] w_d(input logic [11:0] r, input logic [1:0] m, input logic [1:0] a,
                                      input logic en1, input logic en2, input logic f, input logic lg);
    return {8'd0, 4'b1010, r, m, a, en1, en2, f, lg};
  endfunction
  function automatic logic [31:0] w_e(input logic [1:0] t);
    return {8'd0, 4'b1111, 18'd0, t};
  endfunction
  function automatic logic [31:0] w_as(input logic [2:0] f, input logic [11:0] a, input logic [7:0] lo);
    return {8'd0, 1'b0, f, a, lo};
  endfunction
  function automatic logic [31:0] w_al(input logic [2:0] f, input logic [11:0] a, input logic [7:0] lo, input logic [7:0] c);
    return {1'b0, f, a, lo, c};
  endfunction

  task automatic apply_a(input logic [2:0] f, input logic [11:0] a, input logic [7:0] lo, input logic [7:0] c);
    e_fi = f; e_ca = a; e_lo = lo; e_pm = s_pm;
    e_cf = e_lf ? c : s_cf;
  endtask

  task automatic rand_word();
    int k = $urandom_range(0, 4);
    case (k)
      0: begin
        logic [7:0] c = 8'($urandom); logic [3:0] q = 4'($urandom);
        logic [1:0] l = 2'($urandom); logic [1:0] p = ($urandom_range(0,1) != 0) ? 2'b10 : 2'b01;
        send(w_b(c, q, l, p), 24, 0);
        s_cf = c; s_pm = p; e_ia = q; e_pa = l;
      end
      1: begin
        logic [11:0] r = 12'($urandom); logic b = 1'($urandom);
        send(w_c(r, b), 24, 0); e_ar = r; e_ab = b;
      end
      2: begin
        logic [11:0] r = 12'($urandom); logic [7:0] x = 8'($urandom);
        send(w_d(r, x[7:6], x[5:4], x[3], x[2], x[1], x[0]), 24, 0);
        e_rr = r; e_ms = x[7:6]; e_as = x[5:4]; e_me = x[3]; e_ae = x[2];
        e_m8 = x[1]; e_lf = x[0]; e_ts = 2'b00;
      end
      3: begin
        logic [1:0] t = 2'($urandom); send(w_e(t), 24, 0); e_ts = t;
      end
      default: begin
        logic [2:0] f = 3'($urandom); logic [11:0] a = 12'($urandom);
        logic [7:0] lo = 8'($urandom); logic [7:0] c = 8'($urandom);
        if (e_lf) send(w_al(f, a, lo, c), 32, 0);
        else      send(w_as(f, a, lo), 24, 0);
        apply_a(f, a, lo, c);
      end
    endcase
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    {e_fi, e_ca, e_lo, e_cf, e_pm, s_cf, s_pm, e_ia, e_pa} = '0;
    {e_ar, e_ab, e_rr, e_ms, e_as, e_me, e_ae, e_m8, e_lf, e_ts} = '0;
    cyc(4); rst_n = 1'b1; cyc(4);
    check_all("R10");
    chk("R10", "speed", su, 0);

    // R3 R4: setup clears test select; test word sets it
    send(w_e(2'b11), 24, 0); e_ts = 2'b11; check_all("R3");
    send(w_d(12'hA5C, 2'b10, 2'b01, 1, 1, 1, 0), 24, 0);
    e_rr = 12'hA5C; e_ms = 2'b10; e_as = 2'b01; e_me = 1; e_ae = 1; e_m8 = 1; e_ts = 0;
    check_all("R4");
    send(w_c(12'h3F1, 1'b1), 24, 0); e_ar = 12'h3F1; e_ab = 1; check_all("R3");

    // R5: staging not visible until a main word; R7 three-count split
    send(w_b(8'hC3, 4'h9, 2'b11, 2'b10), 24, 0);
    s_cf = 8'hC3; s_pm = 2'b10; e_ia = 4'h9; e_pa = 2'b11;
    check_all("R5");
    send(w_as(3'd5, 12'h123, 8'h7E), 24, 0); apply_a(3'd5, 12'h123, 8'h7E, 8'h0);
    check_all("R7");
    chk("R9", "speed high strobe", su, 1);
    sstb = 1'b0; cyc(4); chk("R9", "speed after strobe low", su, 0);
    sstb = 1'b1; cyc(4);

    // R1: junk edges while strobe high are not counted
    send(w_b(8'h11, 4'h2, 2'b01, 2'b01), 24, 8);
    s_cf = 8'h11; s_pm = 2'b01; e_ia = 4'h2; e_pa = 2'b01; check_all("R1");

    // R2: bad length and unused header ignored
    send(w_b(8'hFF, 4'hF, 2'b00, 2'b10), 25, 0); check_all("R2");
    send({8'd0, 4'b1011, 20'hFFFFF}, 24, 0); check_all("R2");
    send(w_al(3'd1, 12'hFFF, 8'hFF, 8'hFF), 32, 0); check_all("R6");

    // R8: closed window keeps pending; newer word replaces it
    lok = 1'b0;
    send(w_as(3'd2, 12'h456, 8'h21), 24, 0); check_all("R8");
    chk("R8", "speed no commit", su, 0);
    send(w_as(3'd3, 12'h789, 8'h54), 24, 0); check_all("R8");
    lok = 1'b1; cyc(4); apply_a(3'd3, 12'h789, 8'h54, 8'h0);
    check_all("R8");
    chk("R9", "late commit speed", su, 1);

    // R6: long format carries its own current factor; short word ignored
    send(w_d(12'h100, 2'b00, 2'b11, 1, 0, 0, 1), 24, 0);
    e_rr = 12'h100; e_ms = 0; e_as = 3; e_me = 1; e_ae = 0; e_m8 = 0; e_lf = 1; e_ts = 0;
    send(w_as(3'd7, 12'h001, 8'h01), 24, 0); check_all("R6");
    send(w_al(3'd6, 12'hBEE, 8'h9A, 8'h5D), 32, 0); apply_a(3'd6, 12'hBEE, 8'h9A, 8'h5D);
    check_all("R6");

    for (int it = 0; it < 120; it++) begin
      rand_word();
      check_all("R2 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule